// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver Register

This block joins two 18-bit ports, called A and B, and moves data between them in either direction. Each direction has its own output enable, latch enable and strobe. The storage element of a direction does three jobs. It is transparent while its latch enable is high. It holds its value while the latch enable is low and the strobe is steady. It captures the source port on a high-to-low strobe transition while the latch enable is low.

The port that receives data is driven from that direction's storage element and never from its own input. The block models each port as a separate input, output and drive-enable, and a pad ring outside the block turns these into a tri-state bus.

The block runs on a core clock. The two direction strobes are asynchronous inputs. Each strobe is synchronized to the core clock and edge-detected, so the block can be built as a normal ASIC block.

Top module: `univ_bus_xcvr`

## Requirements
- R1: An active-low reset clears both storage elements to zero at once, without waiting for a clock edge. With the latch enables low, `b_out` and `a_out` read zero until the first capture.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle.
- R3: While `ab_le` is 0, `b_out` keeps its stored value when `a_in` changes or `ab_stb` stays steady. A low-to-high transition of `ab_stb` also leaves `b_out` unchanged.
- R4: While `ab_le` is 0, a high-to-low transition of `ab_stb` loads the current `a_in` into the A-to-B storage. The new value appears on `b_out` within SYNC_STAGES+1 core clock cycles. `a_in` must stay stable over that window.
- R5: When `ab_le` goes from 1 to 0, `b_out` keeps the `a_in` value sampled in the last cycle that `ab_le` was high.
- R6: `b_oe` is 1 exactly when `ab_oe` is 1, because the A-to-B enable is active high.
- R7: With the default BA_OE_LOW=1, `a_oe` is 1 exactly when `ba_oe` is 0.
- R8: The B-to-A direction mirrors R2 to R5, using `ba_le`, `ba_stb`, `b_in` and `a_out`.
- R9: Activity in one direction (data, latch enable or strobe) never changes the output of the other direction.
- R10: When both drive enables are asserted together, each port drives its own stored value and not the value on its own input. This is a contention condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_in | input | 18 | Value seen on the A port pins |
| a_out | output | 18 | Value the block drives onto the A port |
| a_oe | output | 1 | A port drive enable (1 = drive) |
| b_in | input | 18 | Value seen on the B port pins |
| b_out | output | 18 | Value the block drives onto the B port |
| b_oe | output | 1 | B port drive enable (1 = drive) |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_stb | input | 1 | A-to-B strobe, captures on its falling transition |
| ba_oe | input | 1 | B-to-A output enable, polarity set by BA_OE_LOW |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_stb | input | 1 | B-to-A strobe, captures on its falling transition |

## Verification
Several alternating and all-ones words are passed through a transparent direction. These show that every bit follows the source and that no bit is stuck. A new word is then applied behind a closed latch, and the strobe is moved in each direction. This separates hold from capture, and shows that a rising strobe is ignored while a falling one loads the word. Distinct words are placed on the two ports, each different from the stored values. Turning on both enables then shows that each port drives its stored word and not its own input, and that the two directions do not disturb each other.

// File: rtl/univ_bus_xcvr_pkg.sv
package univ_bus_xcvr_pkg;
  localparam int unsigned XCVR_W       = 18;
  localparam int unsigned XCVR_SYNC    = 2;
  localparam int unsigned XCVR_NLANE   = 2;
  localparam int unsigned LANE_AB      = 0;
  localparam int unsigned LANE_BA      = 1;

  typedef struct packed {
    logic oe;
    logic le;
    logic stb;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb sync_d[0] = sig_in;

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_comb sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[LAST];
    end
  end

  assign fall = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import univ_bus_xcvr_pkg::*;
#(
  parameter int unsigned W      = XCVR_W,
  parameter int unsigned STAGES = XCVR_SYNC,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  lane_ctrl_t   ctrl,
  output logic [W-1:0] dout,
  output logic         drv_en
);
  logic         stb_fall;
  logic         held_en;
  logic [W-1:0] held_d;
  logic [W-1:0] held_q;

  xcvr_fall_det #(.STAGES(STAGES)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (ctrl.stb),
    .fall   (stb_fall)
  );

  always_comb begin
    held_en = ctrl.le | stb_fall;
    held_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (held_en) held_q <= held_d;
  end

  always_comb begin
    dout   = ctrl.le ? din : held_q;
    drv_en = ctrl.oe ^ OE_LOW;
  end
endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
  import univ_bus_xcvr_pkg::*;
#(
  parameter int unsigned DATA_W      = XCVR_W,
  parameter int unsigned SYNC_STAGES = XCVR_SYNC,
  parameter bit          AB_OE_LOW   = 1'b0,
  parameter bit          BA_OE_LOW   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  input  logic              ab_oe,
  input  logic              ab_le,
  input  logic              ab_stb,
  input  logic              ba_oe,
  input  logic              ba_le,
  input  logic              ba_stb
);
  localparam logic [XCVR_NLANE-1:0] OE_LOW_VEC = {BA_OE_LOW, AB_OE_LOW};

  logic                rst_core_n;
  logic [DATA_W-1:0]   lane_din  [XCVR_NLANE];
  logic [DATA_W-1:0]   lane_dout [XCVR_NLANE];
  logic                lane_en   [XCVR_NLANE];
  lane_ctrl_t          lane_ctl  [XCVR_NLANE];

  xcvr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    lane_din[LANE_AB] = a_in;
    lane_ctl[LANE_AB] = '{oe: ab_oe, le: ab_le, stb: ab_stb};
    lane_din[LANE_BA] = b_in;
    lane_ctl[LANE_BA] = '{oe: ba_oe, le: ba_le, stb: ba_stb};
  end

  for (genvar g = 0; g < XCVR_NLANE; g++) begin : g_lane
    xcvr_lane #(
      .W      (DATA_W),
      .STAGES (SYNC_STAGES),
      .OE_LOW (OE_LOW_VEC[g])
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .din    (lane_din[g]),
      .ctrl   (lane_ctl[g]),
      .dout   (lane_dout[g]),
      .drv_en (lane_en[g])
    );
  end

  always_comb begin
    b_out = lane_dout[LANE_AB];
    b_oe  = lane_en[LANE_AB];
    a_out = lane_dout[LANE_BA];
    a_oe  = lane_en[LANE_BA];
  end
endmodule

// File: rtl/univ_bus_xcvr_chk.sv
module univ_bus_xcvr_chk #(
  parameter int unsigned DATA_W    = 18,
  parameter bit          AB_OE_LOW = 1'b0,
  parameter bit          BA_OE_LOW = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] a_out,
  input logic              a_oe,
  input logic [DATA_W-1:0] b_in,
  input logic [DATA_W-1:0] b_out,
  input logic              b_oe,
  input logic              ab_oe,
  input logic              ab_le,
  input logic              ab_stb,
  input logic              ba_oe,
  input logic              ba_le
);
  logic       stb_q;
  logic [2:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      quiet_q <= '0;
    end else begin
      stb_q <= ab_stb;
      if (stb_q & ~ab_stb)   quiet_q <= '0;
      else if (quiet_q != 3'd7) quiet_q <= quiet_q + 3'd1;
    end
  end

  // R2
  ab_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> (b_out == a_in));

  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $past(!ab_le) && quiet_q >= 3'd5) |-> $stable(b_out));

  // R5
  ab_le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ab_le) |-> (b_out == $past(a_in)));

  // R6
  ab_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe == (ab_oe ^ AB_OE_LOW));

  // R7
  ba_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe == (ba_oe ^ BA_OE_LOW));

  // R8
  ba_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le |-> (a_out == b_in));
endmodule

bind univ_bus_xcvr univ_bus_xcvr_chk #(
  .DATA_W    (DATA_W),
  .AB_OE_LOW (AB_OE_LOW),
  .BA_OE_LOW (BA_OE_LOW)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_in   (a_in),
  .a_out  (a_out),
  .a_oe   (a_oe),
  .b_in   (b_in),
  .b_out  (b_out),
  .b_oe   (b_oe),
  .ab_oe  (ab_oe),
  .ab_le  (ab_le),
  .ab_stb (ab_stb),
  .ba_oe  (ba_oe),
  .ba_le  (ba_le)
);

// File: tb/univ_bus_xcvr_bench.sv
`timescale 1ns/1ps
module univ_bus_xcvr_bench;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;
  logic         ab_oe, ab_le, ab_stb, ba_oe, ba_le, ba_stb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  univ_bus_xcvr u_univ_bus_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_stb(ab_stb),
    .ba_oe(ba_oe), .ba_le(ba_le), .ba_stb(ba_stb)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; a_in = '0; b_in = '0;
    ab_oe = 1'b0; ab_le = 1'b0; ab_stb = 1'b0;
    ba_oe = 1'b1; ba_le = 1'b0; ba_stb = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("R1 b_out after reset", b_out, '0);
    chk("R1 a_out after reset", a_out, '0);
    chk("R6 b_oe idle", {17'd0, b_oe}, 18'd0);
    chk("R7 a_oe idle", {17'd0, a_oe}, 18'd0);
  endtask

  task automatic t_ab_transparent();
    logic [W-1:0] pats [3] = '{18'h2AAAA, 18'h15555, 18'h3FFFF};
    ab_le = 1'b1;
    foreach (pats[i]) begin
      a_in = pats[i];
      step(1);
      chk("R2 transparent", b_out, pats[i]);
    end
  endtask

  task automatic t_ab_hold();
    a_in = 18'h2A5A5; step(2);
    ab_le = 1'b0; step(1);
    chk("R5 value at le fall", b_out, 18'h2A5A5);
    a_in = 18'h00F0F; step(3);
    chk("R3 hold on data change", b_out, 18'h2A5A5);
    ab_stb = 1'b1; step(6);
    chk("R3 rising strobe ignored", b_out, 18'h2A5A5);
  endtask

  task automatic t_ab_capture();
    ab_stb = 1'b0; step(5);
    chk("R4 falling strobe capture", b_out, 18'h00F0F);
    a_in = 18'h3C3C3; step(5);
    chk("R3 hold after capture", b_out, 18'h00F0F);
    chk("R9 a_out untouched by A-to-B", a_out, '0);
  endtask

  task automatic t_enables();
    ab_oe = 1'b1; step(1);
    chk("R6 b_oe on", {17'd0, b_oe}, 18'd1);
    ab_oe = 1'b0; step(1);
    chk("R6 b_oe off", {17'd0, b_oe}, 18'd0);
    ba_oe = 1'b0; step(1);
    chk("R7 a_oe on when ba_oe low", {17'd0, a_oe}, 18'd1);
    ba_oe = 1'b1; step(1);
    chk("R7 a_oe off when ba_oe high", {17'd0, a_oe}, 18'd0);
  endtask

  task automatic t_ba_path();
    ba_le = 1'b1; b_in = 18'h01234; step(2);
    chk("R8 transparent B-to-A", a_out, 18'h01234);
    ba_le = 1'b0; step(1);
    b_in = 18'h3ABCD; step(3);
    chk("R8 hold B-to-A", a_out, 18'h01234);
    ba_stb = 1'b1; step(6);
    chk("R8 rising strobe ignored B-to-A", a_out, 18'h01234);
    ba_stb = 1'b0; step(5);
    chk("R8 capture B-to-A", a_out, 18'h3ABCD);
    chk("R9 b_out untouched by B-to-A", b_out, 18'h00F0F);
  endtask

  task automatic t_contention();
    a_in = 18'h11111; b_in = 18'h22222;
    ab_oe = 1'b1; ba_oe = 1'b0; step(2);
    if (a_oe && b_oe) $display("NOTE R10 contention: both ports driving");
    chk("R10 both enables", {16'd0, a_oe, b_oe}, 18'd3);
    chk("R10 b_out from storage", b_out, 18'h00F0F);
    chk("R10 a_out from storage", a_out, 18'h3ABCD);
    ab_oe = 1'b0; ba_oe = 1'b1; step(1);
  endtask

  task automatic t_reset_mid();
    rst_n = 1'b0; #1;
    chk("R1 async clear b_out", b_out, '0);
    chk("R1 async clear a_out", a_out, '0);
    step(2);
    rst_n = 1'b1; step(4);
    chk("R1 zero after release", b_out, '0);
  endtask

  initial begin
    do_reset();
    t_ab_transparent();
    t_ab_hold();
    t_ab_capture();
    t_enables();
    t_ba_path();
    t_contention();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule